// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block is the slave side of a serial flash read path. It runs directly from the SPI serial clock and chip select, with no system clock. Each transaction begins with an 8-bit instruction. The block then serves one of two things:

- **Byte read:** a 24-bit start address follows the instruction, and the block streams bytes from an internal byte array for as long as chip select stays low.
- **Identification:** the block returns a fixed byte sequence. It starts with four header bytes, then two extended identity bytes, then fourteen configuration bytes, then zero padding.

A busy input stands in for an erase, program or write cycle that is in progress. A read instruction that arrives while busy is high is refused. Raising chip select ends any transaction on any bit and returns every piece of state to its idle value.

The array is a register file of `2**MEM_AW` bytes. Its index is the low `MEM_AW` bits of the 24-bit address counter, so the array repeats across the address space. It is filled through a separate synchronous load port before any reads take place.

Top module: `spi_read_responder`

## Requirements
- R1: While chip select is high, and during the 8 instruction bits, `so_oe` is 0 and `so` is 0.
- R2: Instruction 03h is followed by a 24-bit address, most significant bit first, with each bit sampled on a rising `sck`. The addressed byte is driven most significant bit first, and each bit changes on a falling `sck`. The first data bit is present after the falling edge that follows the last address bit.
- R3: After every full byte, the address counter steps by one. Each byte is read from array entry `addr[MEM_AW-1:0]`.
- R4: Address FFFFFFh is followed by address 000000h, and output continues without a break.
- R5: If `busy` is 1 when the eighth bit of a 03h instruction is sampled, the read is rejected. `so_oe` then stays 0 until chip select rises.
- R6: Chip select going high ends the transaction at any bit and clears `so_oe` at once. The next transaction starts again at the instruction phase.
- R7: Instruction 9Fh returns the following bytes, in this order:
  - 20h, BBh, 18h, 10h;
  - the first extended byte, with bits 1:0 = `ID_ARCH` (00 uniform, 01 bottom, 11 top), bit 3 = `ID_HOLD_RST`, bit 4 = `ID_XIP_REQ`, and every other bit 0;
  - a second extended byte of 00h;
  - fourteen bytes taken from `ID_CFG`, most significant byte first.
- R8: After the twenty identification bytes, the output is 00h until chip select rises.
- R9: Any instruction other than 03h and 9Fh is ignored. `so_oe` stays 0 until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Chip select, active low; a high level resets the transaction |
| si | input | 1 | Serial data in (instruction and address) |
| busy | input | 1 | An internal erase, program or write cycle is in progress |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| ld_clk | input | 1 | Clock for the array load port |
| ld_we | input | 1 | Array load write enable |
| ld_addr | input | MEM_AW | Array load index |
| ld_data | input | 8 | Array load byte |

## Verification
The bench builds the block with `MEM_AW=5`, which gives a 32-byte array. With a small array, the aliasing of high addresses onto low entries can be seen within a few bytes. A start address of FFFFFEh reaches the wrap to zero after two bytes.

The bench also sets `ID_ARCH=11`, `ID_HOLD_RST=1` and `ID_XIP_REQ=1`, and fills `ID_CFG` with C0h to CDh. With these values, every field of the first extended byte is non-zero. Every configuration byte is also distinct, so an ordering fault or a bit-position fault in the identification sequence shows up at the output.

// File: rtl/spi_read_responder.sv
module spi_read_responder #(
  parameter int MEM_AW = 6,
  parameter logic [1:0] ID_ARCH = 2'b00,
  parameter logic ID_HOLD_RST = 1'b0,
  parameter logic ID_XIP_REQ = 1'b0,
  parameter logic [111:0] ID_CFG = '0
) (
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              busy,
  output logic              so,
  output logic              so_oe,
  input  logic              ld_clk,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [4:0] ID_LEN = 5'd20;
  localparam logic [2:0] S_CMD = 3'd0, S_ADDR = 3'd1, S_DATA = 3'd2, S_ID = 3'd3, S_IGN = 3'd4;

  logic [7:0]  mem [DEPTH];
  logic [2:0]  st;
  logic [4:0]  cnt;
  logic [23:0] sh;
  logic [23:0] addr;
  logic [4:0]  idx;
  logic        so_q, oe_q;
  logic [7:0]  id_byte, cur_byte;
  logic [111:0] cfg_sh;
  logic [7:0]  opcode;

  always_ff @(posedge ld_clk)
    if (ld_we) mem[ld_addr] <= ld_data;

  assign opcode = {sh[6:0], si};

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      st <= S_CMD;
      cnt <= '0;
      sh <= '0;
      addr <= '0;
      idx <= '0;
    end else begin
      case (st)
        S_CMD: begin
          sh <= {sh[22:0], si};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            if (opcode == OP_READ) st <= busy ? S_IGN : S_ADDR;
            else if (opcode == OP_IDENT) st <= S_ID;
            else st <= S_IGN;
          end
        end
        S_ADDR: begin
          sh <= {sh[22:0], si};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd23) begin
            addr <= {sh[22:0], si};
            cnt <= '0;
            st <= S_DATA;
          end
        end
        S_DATA: begin
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            addr <= addr + 24'd1;
          end
        end
        S_ID: begin
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            if (idx != ID_LEN) idx <= idx + 5'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cfg_sh = ID_CFG >> {(5'd19 - idx), 3'b000};

  always_comb begin
    case (idx)
      5'd0: id_byte = 8'h20;
      5'd1: id_byte = 8'hBB;
      5'd2: id_byte = 8'h18;
      5'd3: id_byte = 8'h10;
      5'd4: id_byte = {3'b000, ID_XIP_REQ, ID_HOLD_RST, 1'b0, ID_ARCH};
      5'd5: id_byte = 8'h00;
      default: id_byte = (idx < ID_LEN) ? cfg_sh[7:0] : 8'h00;
    endcase
  end

  assign cur_byte = (st == S_DATA) ? mem[addr[MEM_AW-1:0]] : id_byte;

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      so_q <= cur_byte[3'd7 - cnt[2:0]];
      oe_q <= (st == S_DATA) || (st == S_ID);
    end
  end

  assign so_oe = oe_q & ~cs_n;
  assign so = so_q & so_oe;
endmodule

// File: rtl/spi_read_responder_chk.sv
module spi_read_responder_chk (
  input logic        sck,
  input logic        cs_n,
  input logic        so_oe,
  input logic [2:0]  st,
  input logic [23:0] addr,
  input logic [4:0]  idx
);
  logic [5:0] edges;

  always_ff @(posedge sck or posedge cs_n)
    if (cs_n) edges <= '0;
    else if (edges != 6'd63) edges <= edges + 6'd1;

  // R1: nothing is driven before the instruction has been taken in
  assert_no_drive_cmd_R1: assert property (@(posedge sck) disable iff (cs_n)
    (edges < 6'd8) |-> !so_oe);

  // R3: the address steps by exactly one during streaming
  assert_addr_step_R3: assert property (@(posedge sck) disable iff (cs_n)
    (st == 3'd2 && $past(st) == 3'd2 && addr != $past(addr) && $past(addr) != 24'hFFFFFF)
      |-> addr == $past(addr) + 24'd1);

  // R4: the top address is followed by zero
  assert_addr_wrap_R4: assert property (@(posedge sck) disable iff (cs_n)
    (st == 3'd2 && $past(st) == 3'd2 && $past(addr) == 24'hFFFFFF && addr != $past(addr))
      |-> addr == 24'd0);

  // R5 and R9: a rejected or unknown instruction never drives the output
  assert_reject_quiet_R5: assert property (@(posedge sck) disable iff (cs_n)
    (st == 3'd4 && $past(st) == 3'd4) |-> !so_oe);

  // R8: the identification index stops at the end of the sequence
  assert_id_limit_R8: assert property (@(posedge sck) disable iff (cs_n)
    idx <= 5'd20);
endmodule

bind spi_read_responder spi_read_responder_chk u_chk (
  .sck(sck), .cs_n(cs_n), .so_oe(so_oe), .st(st), .addr(addr), .idx(idx)
);

// File: tb/spi_read_responder_bench.sv
module spi_read_responder_bench;
  localparam int AW = 5;
  localparam logic [111:0] CFG = 112'hC0C1C2C3C4C5C6C7C8C9CACBCCCD;

  logic clk = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, busy = 1'b0;
  logic so, so_oe;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  spi_read_responder #(.MEM_AW(AW), .ID_ARCH(2'b11), .ID_HOLD_RST(1'b1),
                       .ID_XIP_REQ(1'b1), .ID_CFG(CFG)) u_spi_read_responder (
    .sck(sck), .cs_n(cs_n), .si(si), .busy(busy), .so(so), .so_oe(so_oe),
    .ld_clk(clk), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data));

  function automatic logic [7:0] memf(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic o, output logic e);
    si = b;
    #20;
    o = so;
    e = so_oe;
    sck = 1'b1;
    #20;
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] v, output logic [7:0] r, output logic anyoe, output logic alloe);
    logic o, e;
    anyoe = 1'b0;
    alloe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bitx(v[i], o, e);
      r[i] = o;
      anyoe |= e;
      alloe &= e;
    end
  endtask

  task automatic start_cmd(input logic [7:0] op, input string req);
    logic [7:0] r;
    logic a, l;
    cs_n = 1'b0;
    #20;
    xbyte(op, r, a, l);
    chk(!a, req, a, 0);
  endtask

  task automatic send_addr(input logic [23:0] ad);
    logic [7:0] r;
    logic a, l;
    for (int k = 2; k >= 0; k--) begin
      xbyte(ad[8*k +: 8], r, a, l);
      chk(!a, "R1", a, 0);
    end
  endtask

  task automatic end_cs;
    #20;
    cs_n = 1'b1;
    #40;
  endtask

  task automatic expect_bytes(input int n, input int first, input string req);
    logic [7:0] r;
    logic a, l;
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r, a, l);
      chk(l && r == memf((first + k) % 32), req, r, memf((first + k) % 32));
    end
  endtask

  task automatic t_reset;
    #1;
    chk(so_oe == 1'b0 && so == 1'b0, "R1", {so_oe, so}, 0);
  endtask

  task automatic t_read_basic;
    start_cmd(8'h03, "R1");
    send_addr(24'h00001D);
    expect_bytes(5, 29, "R2");
    end_cs();
    chk(!so_oe, "R6", so_oe, 0);
  endtask

  task automatic t_alias;
    start_cmd(8'h03, "R1");
    send_addr(24'hABCD27);
    expect_bytes(2, 7, "R3");
    end_cs();
  endtask

  task automatic t_wrap;
    start_cmd(8'h03, "R1");
    send_addr(24'hFFFFFE);
    expect_bytes(4, 30, "R4");
    end_cs();
  endtask

  task automatic t_busy;
    logic [7:0] r;
    logic a, l;
    busy = 1'b1;
    start_cmd(8'h03, "R5");
    busy = 1'b0;
    for (int k = 0; k < 5; k++) begin
      xbyte(8'h00, r, a, l);
      chk(!a, "R5", a, 0);
    end
    end_cs();
    start_cmd(8'h03, "R5");
    send_addr(24'h000002);
    expect_bytes(1, 2, "R5");
    end_cs();
  endtask

  task automatic t_abort;
    logic o, e;
    start_cmd(8'h03, "R1");
    send_addr(24'h000005);
    for (int k = 0; k < 4; k++) bitx(1'b0, o, e);
    chk(e, "R6", e, 1);
    cs_n = 1'b1;
    #5;
    chk(!so_oe, "R6", so_oe, 0);
    #40;
    cs_n = 1'b0;
    for (int k = 0; k < 3; k++) bitx(1'b1, o, e);
    cs_n = 1'b1;
    #40;
    start_cmd(8'h03, "R6");
    send_addr(24'h000009);
    expect_bytes(2, 9, "R6");
    end_cs();
  endtask

  task automatic t_id;
    logic [7:0] r, ex;
    logic a, l;
    start_cmd(8'h9F, "R1");
    for (int k = 0; k < 24; k++) begin
      xbyte(8'h00, r, a, l);
      case (k)
        0: ex = 8'h20;
        1: ex = 8'hBB;
        2: ex = 8'h18;
        3: ex = 8'h10;
        4: ex = 8'h1B;
        5: ex = 8'h00;
        default: ex = (k < 20) ? 8'(8'hC0 + (k - 6)) : 8'h00;
      endcase
      if (k < 20) chk(l && r == ex, "R7", r, ex);
      else chk(l && r == ex, "R8", r, ex);
    end
    end_cs();
  endtask

  task automatic t_badop;
    logic [7:0] r;
    logic a, l;
    start_cmd(8'h0B, "R9");
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, r, a, l);
      chk(!a, "R9", a, 0);
    end
    end_cs();
  endtask

  task automatic load_mem;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_we = 1'b1;
      ld_addr = AW'(i);
      ld_data = memf(i);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  initial begin
    #20 cs_n = 1'b1;
    #20;
    t_reset();
    load_mem();
    t_read_basic();
    t_alias();
    t_wrap();
    t_busy();
    t_abort();
    t_id();
    t_badop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule